// File: doc/BRIEF.md
# Three-Dimensional DMA Address Walker

This block keeps one transfer description and expands it into a stream of array requests for a separate transfer engine. Each request carries a source address, a destination address and a byte count. The description is written as eight 32-bit words while the block is idle. A `go` pulse then arms a walk over up to three nested levels: bytes within an array, arrays within a frame, and frames within a block. Synchronization events pace the walk, and a one-cycle `done` pulse marks the end of the block.

The walk is built around four named states. ST_IDLE waits for `go`. The transition T_ARM captures the start addresses and counts and leads to ST_WAIT. ST_WAIT waits for `sync_ev`, and the transition T_FIRE leads to ST_ISSUE. ST_ISSUE presents one array request per cycle and leaves by one of three transitions. T_PAUSE returns to ST_WAIT after one array in array-paced mode, or after the last array of a frame in frame-paced mode. T_NEXT stays in ST_ISSUE for the next array of the same frame in frame-paced mode. T_END leads to ST_FIN after the last array of the last frame. ST_FIN raises `done` for one cycle and the transition T_RETIRE returns to ST_IDLE.

Each address axis can be held fixed, which suits a peripheral FIFO port. The array stride and the frame stride are signed 16-bit byte offsets. Each frame stride is added to the start address of the frame that has just finished.

Top module: `dma3d_walker`

## Requirements
- R1: Words are written through `cfg_we`/`cfg_idx`/`cfg_wdata` using these indexes: 0 options, 1 source address, 2 destination address, 3 counts (A = bytes per array in bits 15:0, B = arrays per frame in bits 31:16), 4 frame count C in bits 15:0, 5 array strides (source in bits 15:0, destination in bits 31:16), 6 frame strides (same packing), 7 link in bits 15:0 and B reload in bits 31:16. Option bit 0 fixes the source address, bit 1 fixes the destination address, and bit 2 selects frame-paced mode. Bits 10:8 hold a FIFO width that the walker does not decode.
- R2: A `go` pulse in ST_IDLE raises `busy` on the next cycle. No request appears until a `sync_ev` is seen in ST_WAIT. The first request is presented in the cycle after that event and carries the written start addresses.
- R3: In array-paced mode (option bit 2 clear), each event yields exactly one request of A bytes, and `req_valid` is low in the cycle after it. Successive arrays in a frame advance each address by its signed array stride.
- R4: In frame-paced mode (option bit 2 set), each event yields all arrays of one frame on consecutive cycles.
- R5: After the last array of a frame, the next frame begins at the previous frame's start address plus the signed frame stride.
- R6: In array-paced mode, every frame after the first holds B-reload arrays. In frame-paced mode, every frame holds B arrays and the reload value has no effect.
- R7: A fixed axis presents its start address on every request of the block, and its strides are ignored.
- R8: After the last array of frame C, `done` is high for exactly one cycle, and then `busy` is low. A, B, C and the B reload must each be at least one.
- R9: `sync_ev` outside ST_WAIT is ignored. `go` and configuration writes are ignored while `busy` is high, so a later `go` replays the original set.
- R10: While `rst_n` is low, and after reset, `busy`, `req_valid` and `done` are low, and a walk in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a description word |
| cfg_idx | input | 3 | Index of the word being written |
| cfg_wdata | input | 32 | Word value |
| go | input | 1 | Arms a walk of the stored description |
| sync_ev | input | 1 | Synchronization event |
| busy | output | 1 | High from arming until the done cycle inclusive |
| req_valid | output | 1 | An array request is presented this cycle |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_bytes | output | 16 | Bytes in the array (A count) |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
Six descriptions are applied. They mix array-paced and frame-paced stepping, positive, negative and zero strides, one fixed axis at a time, a single-array block, frames of one array, and a reload count that differs from B. Comparing them separates the two pacing rules, reload from no reload, and frame stepping from the frame start versus from the last array. A continuous event storm is applied in both modes to show that events arriving during issue are not counted twice. A rewrite attempted mid-walk, followed by a replay, shows whether the stored set was protected.

// File: rtl/walk_pkg.sv
package walk_pkg;

    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 16;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = 8;
    localparam int IDX_W   = $clog2(NWORDS);

    // word indexes
    localparam int WI_OPT  = 0;
    localparam int WI_SRC  = 1;
    localparam int WI_DST  = 2;
    localparam int WI_CNT  = 3;
    localparam int WI_CCNT = 4;
    localparam int WI_AIDX = 5;
    localparam int WI_FIDX = 6;
    localparam int WI_LINK = 7;

    // option bits
    localparam int OB_SRC_FIX = 0;
    localparam int OB_DST_FIX = 1;
    localparam int OB_FRAME   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_FIN   = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic              frame_mode;
        logic              src_fix;
        logic              dst_fix;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  acnt;
        logic [CNT_W-1:0]  bcnt;
        logic [CNT_W-1:0]  ccnt;
        logic [CNT_W-1:0]  breload;
        logic [CNT_W-1:0]  src_astep;
        logic [CNT_W-1:0]  dst_astep;
        logic [CNT_W-1:0]  src_fstep;
        logic [CNT_W-1:0]  dst_fstep;
    } walk_cfg_t;

endpackage

// File: rtl/walk_param_bank.sv
module walk_param_bank
    import walk_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int NW = NWORDS,
    parameter int IW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          lock,
    input  logic [IW-1:0] idx,
    input  logic [WW-1:0] wdata,
    output walk_cfg_t     cfg
);
    localparam int HALF = WW / 2;

    logic [WW-1:0] words [NW];

    generate
        for (genvar g = 0; g < NW; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words[g] <= '0;
                end else if (we && !lock && (idx == IW'(g))) begin
                    words[g] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        cfg.frame_mode = words[WI_OPT][OB_FRAME];
        cfg.src_fix    = words[WI_OPT][OB_SRC_FIX];
        cfg.dst_fix    = words[WI_OPT][OB_DST_FIX];
        cfg.src        = words[WI_SRC][ADDR_W-1:0];
        cfg.dst        = words[WI_DST][ADDR_W-1:0];
        cfg.acnt       = words[WI_CNT][HALF-1:0];
        cfg.bcnt       = words[WI_CNT][WW-1:HALF];
        cfg.ccnt       = words[WI_CCNT][HALF-1:0];
        cfg.src_astep  = words[WI_AIDX][HALF-1:0];
        cfg.dst_astep  = words[WI_AIDX][WW-1:HALF];
        cfg.src_fstep  = words[WI_FIDX][HALF-1:0];
        cfg.dst_fstep  = words[WI_FIDX][WW-1:HALF];
        cfg.breload    = words[WI_LINK][WW-1:HALF];
    end
endmodule

// File: rtl/walk_axis_gen.sv
module walk_axis_gen #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step_arr,
    input  logic          step_frm,
    input  logic          fixed,
    input  logic [SW-1:0] arr_stride,
    input  logic [SW-1:0] frm_stride,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] frm_start;
    logic [AW-1:0] arr_ext;
    logic [AW-1:0] frm_ext;
    logic [AW-1:0] next_frm;

    assign arr_ext  = {{(AW-SW){arr_stride[SW-1]}}, arr_stride};
    assign frm_ext  = {{(AW-SW){frm_stride[SW-1]}}, frm_stride};
    assign next_frm = frm_start + frm_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            frm_start <= '0;
        end else if (load) begin
            addr      <= base;
            frm_start <= base;
        end else if (!fixed) begin
            if (step_frm) begin
                addr      <= next_frm;
                frm_start <= next_frm;
            end else if (step_arr) begin
                addr <= addr + arr_ext;
            end
        end
    end
endmodule

// File: rtl/walk_count_gen.sv
module walk_count_gen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] b_init,
    input  logic [CW-1:0] c_init,
    input  logic          step,
    input  logic [CW-1:0] b_refill,
    output logic          last_arr,
    output logic          last_frm
);
    logic [CW-1:0] b_left;
    logic [CW-1:0] c_left;

    assign last_arr = (b_left == CW'(1));
    assign last_frm = (c_left == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_left <= '0;
            c_left <= '0;
        end else if (load) begin
            b_left <= b_init;
            c_left <= c_init;
        end else if (step) begin
            if (!last_arr) begin
                b_left <= b_left - CW'(1);
            end else if (!last_frm) begin
                c_left <= c_left - CW'(1);
                b_left <= b_refill;
            end
        end
    end
endmodule

// File: rtl/dma3d_walker.sv
module dma3d_walker
    import walk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int CW  = CNT_W,
    parameter int WW  = WORD_W,
    parameter int NW  = NWORDS,
    parameter int IW  = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [WW-1:0] cfg_wdata,
    input  logic          go,
    input  logic          sync_ev,
    output logic          busy,
    output logic          req_valid,
    output logic [AW-1:0] req_src,
    output logic [AW-1:0] req_dst,
    output logic [CW-1:0] req_bytes,
    output logic          done
);
    localparam int NAXIS = 2;

    walk_state_e state, state_nx;
    walk_cfg_t   cfg;

    logic          arm;
    logic          issuing;
    logic          last_arr;
    logic          last_frm;
    logic          step_arr;
    logic          step_frm;
    logic          ab_sel;
    logic          src_fix;
    logic [CW-1:0] refill;

    logic [AW-1:0] ax_base   [NAXIS];
    logic          ax_fixed  [NAXIS];
    logic [CW-1:0] ax_astep  [NAXIS];
    logic [CW-1:0] ax_fstep  [NAXIS];
    logic [AW-1:0] ax_addr   [NAXIS];

    walk_param_bank #(.WW(WW), .NW(NW), .IW(IW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .lock  (busy),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign ab_sel   = cfg.frame_mode;
    assign src_fix  = cfg.src_fix;
    assign arm      = (state == ST_IDLE) && go;
    assign issuing  = (state == ST_ISSUE);
    assign step_arr = issuing && !last_arr;
    assign step_frm = issuing && last_arr && !last_frm;
    assign refill   = ab_sel ? cfg.bcnt : cfg.breload;

    walk_count_gen #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (arm),
        .b_init   (cfg.bcnt),
        .c_init   (cfg.ccnt),
        .step     (issuing),
        .b_refill (refill),
        .last_arr (last_arr),
        .last_frm (last_frm)
    );

    always_comb begin
        ax_base[0]  = cfg.src;
        ax_fixed[0] = cfg.src_fix;
        ax_astep[0] = cfg.src_astep;
        ax_fstep[0] = cfg.src_fstep;
        ax_base[1]  = cfg.dst;
        ax_fixed[1] = cfg.dst_fix;
        ax_astep[1] = cfg.dst_astep;
        ax_fstep[1] = cfg.dst_fstep;
    end

    generate
        for (genvar g = 0; g < NAXIS; g++) begin : g_axis
            walk_axis_gen #(.AW(AW), .SW(CW)) u_axis (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (arm),
                .base       (ax_base[g]),
                .step_arr   (step_arr),
                .step_frm   (step_frm),
                .fixed      (ax_fixed[g]),
                .arr_stride (ax_astep[g]),
                .frm_stride (ax_fstep[g]),
                .addr       (ax_addr[g])
            );
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go) state_nx = ST_WAIT;                   // T_ARM
            end
            ST_WAIT: begin
                if (sync_ev) state_nx = ST_ISSUE;             // T_FIRE
            end
            ST_ISSUE: begin
                if (last_arr && last_frm) state_nx = ST_FIN;  // T_END
                else if (last_arr || !ab_sel) state_nx = ST_WAIT; // T_PAUSE
                else state_nx = ST_ISSUE;                     // T_NEXT
            end
            ST_FIN: begin
                state_nx = ST_IDLE;                           // T_RETIRE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        req_valid = (state == ST_ISSUE);
        done      = (state == ST_FIN);
        req_src   = ax_addr[0];
        req_dst   = ax_addr[1];
        req_bytes = cfg.acnt;
    end
endmodule

// File: rtl/walk_checks.sv
module walk_checks #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic          busy,
    input logic          req_valid,
    input logic [AW-1:0] req_src,
    input logic [CW-1:0] req_bytes,
    input logic          done,
    input logic          ab_sel,
    input logic          src_fix
);
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> (busy && !req_valid));

    p_req_in_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    p_one_per_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ab_sel) |=> !req_valid);

    p_bytes_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!req_valid || $stable(req_bytes)));

    p_fixed_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && src_fix) |=> (!req_valid || $stable(req_src)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!req_valid && !done));
endmodule

bind dma3d_walker walk_checks #(.AW(AW), .CW(CW)) u_walk_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .busy      (busy),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_bytes (req_bytes),
    .done      (done),
    .ab_sel    (ab_sel),
    .src_fix   (src_fix)
);

// File: tb/dma3d_walker_test.sv
module dma3d_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS      = 6;
    localparam int WATCHDOG   = 100000;

    // option words: bit0 src fixed, bit1 dst fixed, bit2 frame-paced, 10:8 FIFO width
    localparam logic [31:0] T_OPT  [NSETS] = '{32'h4, 32'h0, 32'h306, 32'h201, 32'h4, 32'h0};
    localparam logic [31:0] T_SRC  [NSETS] = '{32'h1000, 32'h3000, 32'h5000, 32'h7000, 32'h9000, 32'hB000};
    localparam logic [31:0] T_DST  [NSETS] = '{32'h2000, 32'h4000, 32'h6000, 32'h8000, 32'hA000, 32'hC000};
    localparam logic [15:0] T_A    [NSETS] = '{16'd4, 16'd2, 16'd8, 16'd1, 16'd16, 16'd3};
    localparam logic [15:0] T_B    [NSETS] = '{16'd3, 16'd2, 16'd2, 16'd1, 16'd1, 16'd3};
    localparam logic [15:0] T_C    [NSETS] = '{16'd2, 16'd3, 16'd2, 16'd1, 16'd3, 16'd2};
    localparam logic [15:0] T_SBI  [NSETS] = '{16'h4, 16'hFFFC, 16'h8, 16'h1, 16'h0, 16'h3};
    localparam logic [15:0] T_DBI  [NSETS] = '{16'h8, 16'h2, 16'h8, 16'h1, 16'h10, 16'h3};
    localparam logic [15:0] T_SCI  [NSETS] = '{16'h20, 16'hFFF0, 16'h40, 16'h1, 16'hFF00, 16'h0};
    localparam logic [15:0] T_DCI  [NSETS] = '{16'h40, 16'h100, 16'h40, 16'h1, 16'h10, 16'h0};
    localparam logic [15:0] T_REL  [NSETS] = '{16'd7, 16'd4, 16'd1, 16'd1, 16'd2, 16'd1};
    localparam bit          T_STORM[NSETS] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam bit          T_MED  [NSETS] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        go = 1'b0;
    logic        sync_ev = 1'b0;
    logic        busy, req_valid, done;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_bytes;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dma3d_walker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .go        (go),
        .sync_ev   (sync_ev),
        .busy      (busy),
        .req_valid (req_valid),
        .req_src   (req_src),
        .req_dst   (req_dst),
        .req_bytes (req_bytes),
        .done      (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic write_word(input int idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 3'(idx);
        cfg_wdata = val;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // R1: word indexes and field packing
    task automatic load_set(input int i);
        write_word(0, T_OPT[i]);
        write_word(1, T_SRC[i]);
        write_word(2, T_DST[i]);
        write_word(3, {T_B[i], T_A[i]});
        write_word(4, {16'h0, T_C[i]});
        write_word(5, {T_DBI[i], T_SBI[i]});
        write_word(6, {T_DCI[i], T_SCI[i]});
        write_word(7, {T_REL[i], 16'hFFFF});
    endtask

    task automatic run_set(input int i, input bit meddle);
        bit          ab, sfix, dfix, got_done, med_done, prev_v;
        int          f, j, flen, nreq, cyc, total;
        logic [31:0] es, ed;
        ab   = T_OPT[i][2];
        sfix = T_OPT[i][0];
        dfix = T_OPT[i][1];
        total = ab ? (int'(T_B[i]) * int'(T_C[i]))
                   : (int'(T_B[i]) + (int'(T_C[i]) - 1) * int'(T_REL[i]));
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check(busy && !req_valid, "R2", "armed without request", {busy, req_valid}, 2'b10);
        f = 0; j = 0; flen = int'(T_B[i]); nreq = 0; cyc = 0;
        got_done = 0; med_done = 0; prev_v = 0;
        sync_ev = 1'b0;
        while (!got_done && cyc < 2000) begin
            cyc++;
            cfg_we = 1'b0;
            go     = 1'b0;
            if (req_valid) begin
                es = sfix ? T_SRC[i] : T_SRC[i] + 32'(f) * sx(T_SCI[i]) + 32'(j) * sx(T_SBI[i]);
                ed = dfix ? T_DST[i] : T_DST[i] + 32'(f) * sx(T_DCI[i]) + 32'(j) * sx(T_DBI[i]);
                // R3 stride, R5 frame stride, R6 frame length, R7 fixed axis
                check(req_src == es && req_dst == ed && req_bytes == T_A[i],
                      "R3/R5/R6/R7", $sformatf("set %0d req %0d", i, nreq),
                      {req_src, req_dst, 16'h0, req_bytes}, {es, ed, 16'h0, T_A[i]});
                if (!ab && prev_v)
                    check(1'b0, "R3", "back-to-back request in array-paced mode", 1, 0);
                if (ab && prev_v && j == 0)
                    check(1'b0, "R4", "frame not separated by event", 1, 0);
                if (ab && !prev_v && j != 0)
                    check(1'b0, "R4", "gap inside frame", 0, 1);
                nreq++;
                j++;
                if (j == flen) begin
                    j = 0;
                    f++;
                    flen = ab ? int'(T_B[i]) : int'(T_REL[i]);
                end
            end
            prev_v = req_valid;
            if (done) begin
                got_done = 1;
                check(nreq == total && f == int'(T_C[i]), "R8", "done after last array",
                      {32'(nreq), 32'(f)}, {32'(total), 32'(T_C[i])});
                sync_ev = T_STORM[i];
            end else if (meddle && !med_done && busy && !req_valid) begin
                // R9: write and re-arm attempts while busy
                cfg_we    = 1'b1;
                cfg_idx   = 3'd1;
                cfg_wdata = 32'hDEAD_0000;
                go        = 1'b1;
                sync_ev   = 1'b0;
                med_done  = 1;
            end else begin
                sync_ev = T_STORM[i] ? 1'b1 : (busy && !req_valid);
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        go     = 1'b0;
        check(got_done, "R8", "done seen", {95'h0, got_done}, 1);
        check(!done && !busy && !req_valid, "R8", "single done cycle then idle",
              {done, busy, req_valid}, 3'b000);
        sync_ev = 1'b0;
        @(negedge clk);
        check(!req_valid && !busy, "R9", "event after done ignored",
              {req_valid, busy}, 2'b00);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(!busy && !req_valid && !done, "R10", "outputs in reset",
              {busy, req_valid, done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R10", "outputs after reset",
              {busy, req_valid, done}, 3'b000);

        // R9: events while idle do nothing
        sync_ev = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!req_valid && !busy, "R9", "idle event", {req_valid, busy}, 2'b00);
        end
        sync_ev = 1'b0;

        // table walk
        for (int i = 0; i < NSETS; i++) begin
            load_set(i);
            run_set(i, T_MED[i]);
            if (T_MED[i]) run_set(i, 1'b0); // R9 replay shows stored set untouched
        end

        // R10: reset in the middle of a walk
        load_set(0);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        sync_ev = 1'b1;
        @(negedge clk);
        sync_ev = 1'b0;
        check(req_valid, "R4", "first frame started", {95'h0, req_valid}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R10", "walk abandoned by reset",
              {busy, req_valid, done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid, "R10", "idle after mid-walk reset",
              {busy, req_valid}, 2'b00);

        finish_run();
    end
endmodule